// File: doc/BRIEF.md
# Configuration Space Address Translator

This block sits between a root-complex configuration request source and the memory-mapped window that holds downstream configuration space. Each request names a bus number, a device/function number and a register offset within that function. The block either turns the request into a 64-bit byte address inside the window or refuses it. A refused request issues nothing downstream and completes with all-ones read data, as an absent function would.

Software programs the block through four 32-bit words, selected by a 2-bit index:

| Index | Contents |
|-------|----------|
| 0 | Read-only presence flag |
| 1 | Control word: an enable bit and a 5-bit last-bus field |
| 2 | Low half of the window base |
| 3 | High half of the window base |

A link-status input gates every access beyond the root bus.

The decision runs through a small state machine with three states:

- `ST_IDLE`: no response is presented.
- `ST_GRANT`: a translated address is presented for one cycle.
- `ST_REJECT`: a refusal is presented for one cycle.

From any state, the next state is chosen the same way:

- Taking a request that passes every rule moves the machine to `ST_GRANT`.
- Taking a request that fails any rule moves it to `ST_REJECT`.
- A cycle without a request returns it to `ST_IDLE`.

Because a new request can be taken from either response state, requests may arrive on every cycle.

Top module: `ecam_xlate`

## Requirements
- R1: After reset, the control word (index 1) reads 0x000C0000: enable bit 0 clear and last-bus field (bits 20:16) equal to 12. Both base words (indices 2 and 3) read 0, and no response is valid.
- R2: Index 0 reads 0x00000001 (bit 0 set, meaning translation support is present), and writes to index 0 have no effect on the value read back.
- R3: In the control word, only bit 0 (enable) and bits 20:16 (last usable bus number) are stored; every other bit reads as 0.
- R4: The window base is 64 bits wide. Index 2 holds bits 31:0 and index 3 holds bits 63:32, and each reads back what was written.
- R5: A granted request yields the address base + ((bus << 20) | (devfn << 12) | offset), with the full 64-bit carry into the high word.
- R6: While the enable bit is clear, every request is rejected.
- R7: On the root bus (bus 0), only device/function 0 is accepted, and it is accepted even while the link is down. Any nonzero device/function on bus 0 is rejected.
- R8: A request to any bus other than bus 0 is rejected while link_up is low.
- R9: A bus number greater than the last-bus field is rejected. A bus number equal to it is accepted.
- R10: A response carries exactly one of grant or reject. On reject, rsp_rdata is 0xFFFFFFFF and rsp_addr is 0. On grant, rsp_rdata is 0.
- R11: Every request produces exactly one response in the next cycle, in request order, even when requests arrive back to back. A cycle without a request produces no response in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index (0 presence, 1 control, 2 base low, 3 base high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| link_up | input | 1 | Link trained and usable |
| req_valid | input | 1 | Configuration request strobe |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_ofs | input | 12 | Register byte offset within the function |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request accepted; rsp_addr is valid |
| rsp_reject | output | 1 | Request refused |
| rsp_addr | output | 64 | Translated window address |
| rsp_rdata | output | 32 | Completion fill: all ones on reject, zero on grant |

## Verification
Register reads are combinational, so the bench checks them one time step after it sets the index, within the same cycle. A request is due exactly one clock after it is driven: it is captured on the rising edge, and the response is presented for that single cycle. The driver pushes each expected outcome into a queue when it drives the request. The monitor samples on falling edges and pops one entry for every valid response. A response that arrives with an empty queue, or an entry still in the queue at the end, is reported as a missed or extra response.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REJECT = 2'd2
    } xl_state_e;

    localparam logic [1:0] IDX_PRESENT = 2'd0;
    localparam logic [1:0] IDX_CTRL    = 2'd1;
    localparam logic [1:0] IDX_BASE_LO = 2'd2;
    localparam logic [1:0] IDX_BASE_HI = 2'd3;

    localparam int CTRL_LAST_LSB = 16;

endpackage

// File: rtl/ecam_regs.sv
module ecam_regs
    import ecam_pkg::*;
#(
    parameter int         SIZE_W       = 5,
    parameter int         SIZE_DEFAULT = 12,
    parameter bit         PRESENT      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ctl_en,
    output logic [SIZE_W-1:0] ctl_last,
    output logic [63:0]       win_base
);

    localparam logic [SIZE_W-1:0] LAST_RST = SIZE_W'(SIZE_DEFAULT);

    logic [31:0] base_lo_q;
    logic [31:0] base_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_last  <= LAST_RST;
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_idx)
                IDX_CTRL: begin
                    ctl_en   <= reg_wdata[0];
                    ctl_last <= reg_wdata[CTRL_LAST_LSB +: SIZE_W];
                end
                IDX_BASE_LO: base_lo_q <= reg_wdata;
                IDX_BASE_HI: base_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign win_base = {base_hi_q, base_lo_q};

    always_comb begin
        unique case (reg_idx)
            IDX_PRESENT: reg_rdata = {31'd0, PRESENT};
            IDX_CTRL:    reg_rdata = (32'(ctl_last) << CTRL_LAST_LSB) | {31'd0, ctl_en};
            IDX_BASE_LO: reg_rdata = base_lo_q;
            default:     reg_rdata = base_hi_q;
        endcase
    end

endmodule

// File: rtl/ecam_gate.sv
module ecam_gate #(
    parameter int BUS_W    = 8,
    parameter int DEVFN_W  = 8,
    parameter int SIZE_W   = 5,
    parameter int ROOT_BUS = 0
) (
    input  logic               en,
    input  logic [SIZE_W-1:0]  last_bus,
    input  logic               link_up,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    output logic               ok
);

    localparam int CMP_W = (BUS_W > SIZE_W) ? BUS_W : SIZE_W;
    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic on_root;
    logic root_fn_bad;
    logic down_blocked;
    logic past_last;

    always_comb begin
        on_root      = (bus == ROOT);
        root_fn_bad  = on_root && (devfn != '0);
        down_blocked = !on_root && !link_up;
        past_last    = CMP_W'(bus) > CMP_W'(last_bus);
        ok           = en && !root_fn_bad && !down_blocked && !past_last;
    end

endmodule

// File: rtl/ecam_compose.sv
module ecam_compose #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int REG_W   = 12,
    parameter int ADDR_W  = 64
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [REG_W-1:0]   ofs,
    output logic [ADDR_W-1:0]  addr
);

    localparam int DEV_SHIFT = REG_W;
    localparam int BUS_SHIFT = REG_W + DEVFN_W;
    localparam int OFS_W     = BUS_SHIFT + BUS_W;

    logic [OFS_W-1:0] rel;

    always_comb begin
        rel  = (OFS_W'(bus) << BUS_SHIFT) | (OFS_W'(devfn) << DEV_SHIFT) | OFS_W'(ofs);
        addr = base + ADDR_W'(rel);
    end

endmodule

// File: rtl/ecam_xlate.sv
module ecam_xlate
    import ecam_pkg::*;
#(
    parameter int BUS_W        = 8,
    parameter int DEVFN_W      = 8,
    parameter int REG_W        = 12,
    parameter int SIZE_W       = 5,
    parameter int SIZE_DEFAULT = 12,
    parameter int ROOT_BUS     = 0,
    parameter bit PRESENT      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               link_up,
    input  logic               req_valid,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [REG_W-1:0]   req_ofs,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_reject,
    output logic [63:0]        rsp_addr,
    output logic [31:0]        rsp_rdata
);

    localparam int ADDR_W = 64;

    logic              ctl_en;
    logic [SIZE_W-1:0] ctl_last;
    logic [63:0]       win_base;
    logic              req_ok;
    logic [63:0]       xl_addr;
    logic [63:0]       addr_q;
    xl_state_e         state_q;
    xl_state_e         state_d;

    ecam_regs #(
        .SIZE_W      (SIZE_W),
        .SIZE_DEFAULT(SIZE_DEFAULT),
        .PRESENT     (PRESENT)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_idx  (reg_idx),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ctl_en   (ctl_en),
        .ctl_last (ctl_last),
        .win_base (win_base)
    );

    ecam_gate #(
        .BUS_W   (BUS_W),
        .DEVFN_W (DEVFN_W),
        .SIZE_W  (SIZE_W),
        .ROOT_BUS(ROOT_BUS)
    ) i_gate (
        .en      (ctl_en),
        .last_bus(ctl_last),
        .link_up (link_up),
        .bus     (req_bus),
        .devfn   (req_devfn),
        .ok      (req_ok)
    );

    ecam_compose #(
        .BUS_W  (BUS_W),
        .DEVFN_W(DEVFN_W),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) i_compose (
        .base (win_base),
        .bus  (req_bus),
        .devfn(req_devfn),
        .ofs  (req_ofs),
        .addr (xl_addr)
    );

    // Next-state decision: every state reacts to a request the same way,
    // so back-to-back requests are taken without a bubble.
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_REJECT: begin
                if (!req_valid)  state_d = ST_IDLE;
                else if (req_ok) state_d = ST_GRANT;
                else             state_d = ST_REJECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) addr_q <= req_ok ? xl_addr : '0;
        end
    end

    // Outputs from the current state.
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_grant  = 1'b0;
        rsp_reject = 1'b0;
        rsp_addr   = '0;
        rsp_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b1;
                rsp_addr  = addr_q;
            end
            ST_REJECT: begin
                rsp_valid  = 1'b1;
                rsp_reject = 1'b1;
                rsp_rdata  = '1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ecam_xlate_chk.sv
module ecam_xlate_chk #(
    parameter int BUS_W    = 8,
    parameter int DEVFN_W  = 8,
    parameter int ROOT_BUS = 0,
    parameter bit PRESENT  = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         reg_idx,
    input logic [31:0]        reg_rdata,
    input logic               ctl_en,
    input logic               link_up,
    input logic               req_valid,
    input logic [BUS_W-1:0]   req_bus,
    input logic [DEVFN_W-1:0] req_devfn,
    input logic               rsp_valid,
    input logic               rsp_grant,
    input logic               rsp_reject,
    input logic [63:0]        rsp_addr,
    input logic [31:0]        rsp_rdata
);

    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_grant, rsp_reject}) == 32'(rsp_valid));

    p_reject_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (rsp_rdata == 32'hFFFF_FFFF) && (rsp_addr == 64'd0));

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_en) |=> rsp_reject);

    p_root_fn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bus == ROOT && req_devfn != '0) |=> rsp_reject);

    p_link_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bus != ROOT && !link_up) |=> rsp_reject);

    p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 2'd0) |-> (reg_rdata == {31'd0, PRESENT}));

endmodule

bind ecam_xlate ecam_xlate_chk #(
    .BUS_W   (BUS_W),
    .DEVFN_W (DEVFN_W),
    .ROOT_BUS(ROOT_BUS),
    .PRESENT (PRESENT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_rdata (reg_rdata),
    .ctl_en    (ctl_en),
    .link_up   (link_up),
    .req_valid (req_valid),
    .req_bus   (req_bus),
    .req_devfn (req_devfn),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_reject(rsp_reject),
    .rsp_addr  (rsp_addr),
    .rsp_rdata (rsp_rdata)
);

// File: tb/test_ecam_xlate.sv
`timescale 1ns/1ps
module test_ecam_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_ofs = '0;
    logic        rsp_valid;
    logic        rsp_grant;
    logic        rsp_reject;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    bit          m_en   = 1'b0;
    int          m_last = 12;
    logic [63:0] m_base = '0;

    bit          q_rej[$];
    logic [63:0] q_addr[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    ecam_xlate i_ecam_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .req_valid(req_valid), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_ofs(req_ofs), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_reject(rsp_reject), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        reg_idx = idx;
        #1;
        check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    // Driver: drive one request for one cycle, push the expected outcome.
    task automatic send(input int bus, input int devfn, input int ofs, input string tag);
        bit rej;
        logic [63:0] a;
        rej = !m_en || (bus > m_last) || (bus == 0 && devfn != 0) || (bus != 0 && !link_up);
        a = rej ? 64'd0 : m_base + ((64'(bus) << 20) | (64'(devfn) << 12) | 64'(ofs));
        q_rej.push_back(rej); q_addr.push_back(a); q_tag.push_back(tag);
        req_valid = 1'b1; req_bus = 8'(bus); req_devfn = 8'(devfn); req_ofs = 12'(ofs);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare each response at the falling edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_rej.size() == 0) begin
                check(1'b0, "R11 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                bit rej;
                logic [63:0] a;
                string t;
                rej = q_rej.pop_front(); a = q_addr.pop_front(); t = q_tag.pop_front();
                check(rsp_reject == rej && rsp_grant == !rej, t, 64'({rsp_grant, rsp_reject}), 64'({!rej, rej}));
                check(rsp_addr == a, {t, " addr"}, rsp_addr, a);
                check(rsp_rdata == (rej ? 32'hFFFF_FFFF : 32'd0), "R10 fill", 64'(rsp_rdata),
                      rej ? 64'hFFFF_FFFF : 64'd0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rd_check(2'd1, 32'h000C_0000, "R1 control reset");
        rd_check(2'd2, 32'd0, "R1 base low reset");
        rd_check(2'd3, 32'd0, "R1 base high reset");
        // R2 presence flag, write ignored
        rd_check(2'd0, 32'd1, "R2 presence");
        @(negedge clk);
        wr(2'd0, 32'd0);
        rd_check(2'd0, 32'd1, "R2 presence after write");
        @(negedge clk);
        // R6 disabled
        send(0, 0, 0, "R6 disabled root");
        send(1, 0, 4, "R6 disabled downstream");
        @(negedge clk);
        // R3 control storage
        wr(2'd1, 32'hFFFF_FFFF);
        rd_check(2'd1, 32'h001F_0001, "R3 control mask");
        @(negedge clk);
        wr(2'd1, 32'h000C_0001);
        m_en = 1'b1; m_last = 12;
        // R4 base
        wr(2'd2, 32'h1000_0000);
        wr(2'd3, 32'h0000_0005);
        m_base = 64'h0000_0005_1000_0000;
        rd_check(2'd2, 32'h1000_0000, "R4 base low");
        rd_check(2'd3, 32'h0000_0005, "R4 base high");
        @(negedge clk);
        // R7 root bus with link down
        link_up = 1'b0;
        send(0, 0, 'h10, "R7 root devfn0 link down");
        send(0, 8, 'h10, "R7 root devfn8");
        // R8 downstream with link down
        send(1, 0, 0, "R8 downstream link down");
        @(negedge clk);
        link_up = 1'b1;
        // R5 translation
        send(1, 'h0A, 'hFFC, "R5 translate bus1");
        send(5, 'hFF, 'h123, "R5 translate bus5");
        // R9 last-bus boundary
        send(12, 0, 0, "R9 bus equal last");
        send(13, 0, 0, "R9 bus above last");
        send(255, 0, 0, "R9 bus 255");
        send(0, 1, 0, "R7 root devfn1 link up");
        repeat (2) @(negedge clk);
        // R5 carry into high word
        wr(2'd2, 32'hFFF0_0000);
        m_base = 64'h0000_0005_FFF0_0000;
        send(1, 0, 8, "R5 carry into high");
        @(negedge clk);
        // R9 larger last-bus value
        wr(2'd1, 32'h001F_0001);
        m_last = 31;
        send(31, 3, 'h40, "R9 bus 31 last 31");
        send(32, 0, 0, "R9 bus 32 last 31");
        repeat (3) @(negedge clk);
        check(q_rej.size() == 0, "R11 all responses seen", 64'(q_rej.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", 64'(cycles), 64'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule